// File: doc/BRIEF.md
# Circular-Buffer Internet Checksum Engine

This block computes the 16-bit Internet checksum over a byte range held in a packet buffer. A host supplies an inclusive first-byte pointer and an inclusive last-byte pointer, both 13 bits wide, together with the bounds of a circular receive region. It then raises a checksum-mode enable and pulses a start request. The engine latches the range and streams one byte per clock from an external memory through a synchronous read port with one cycle of latency. It pairs the bytes into big-endian 16-bit words and keeps a running sum with end-around carry. When the last byte has been consumed it stores the bitwise complement of that sum.

The engine only reads. It has no memory write port and never alters the host's pointers. The busy indication is the start bit, which the hardware clears on completion while setting a sticky done flag. An interrupt line follows that flag, gated by a per-source enable and a global enable. A range that runs past the top of the receive region continues at the bottom of the region, so a wrapped packet completes normally.

Top module: `inet_csum_engine`

## Requirements
- R1: Bytes are paired in order, with the first byte of each pair as bits 15:8 of a word. Words are summed with every carry out of bit 15 added back into bit 0, and the stored result is the bitwise inverse of the final sum.
- R2: An odd-length range is summed as if a 00h byte followed its last byte. For the bytes 89h, ABh, CDh the result is A953h.
- R3: While busy, the engine asserts `mem_rd_en` for exactly one cycle per byte of the range, on consecutive cycles, and steps `mem_addr` from the first pointer to the last. It never asserts `mem_rd_en` while idle.
- R4: Both pointers are inclusive. Equal first and last pointers give a one-byte range, whose result is the inverse of {byte, 00h}.
- R5: The address that follows `ring_hi` is `ring_lo`. The address that follows 1FFFh is 0000h.
- R6: A start request is accepted only when `mode_csum` is 1 in the same cycle. Otherwise `go_bit` stays 0 and no read is issued.
- R7: For an N-byte range, `go_bit` is 1 from the edge that accepts the request and falls exactly N+1 clock edges later. On that same edge `done_flag` becomes 1.
- R8: `irq` is 1 in the cycle after one in which `done_flag`, `irq_en_src` and `irq_en_glb` are all 1, and 0 otherwise. A pulse on `flag_clr` clears `done_flag`, but a completion on the same edge takes priority.
- R9: The result appears as `sum_hi` (bits 15:8) and `sum_lo` (bits 7:0). It holds its previous value until the completing edge of the next computation.
- R10: A start request made while `go_bit` is 1 is ignored. The run in progress finishes with its original range and timing.
- R11: After reset, `go_bit`, `done_flag`, `irq` and `mem_rd_en` are 0, and the result is 0000h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_csum | input | 1 | Checksum-mode enable; must be 1 for a start request to be accepted |
| go_set | input | 1 | Start request pulse |
| flag_clr | input | 1 | Host clear of the done flag |
| irq_en_src | input | 1 | Per-source interrupt enable |
| irq_en_glb | input | 1 | Global interrupt enable |
| ptr_start | input | 13 | First byte of the range (inclusive) |
| ptr_end | input | 13 | Last byte of the range (inclusive) |
| ring_lo | input | 13 | Lowest address of the circular region |
| ring_hi | input | 13 | Highest address of the circular region |
| mem_rd_en | output | 1 | Buffer read enable |
| mem_addr | output | 13 | Buffer read address |
| mem_rd_data | input | 8 | Read data, valid one cycle after the read |
| go_bit | output | 1 | Start/busy bit, cleared by hardware on completion |
| done_flag | output | 1 | Sticky completion flag |
| irq | output | 1 | Gated interrupt request |
| sum_hi | output | 8 | Result bits 15:8 |
| sum_lo | output | 8 | Result bits 7:0 |

## Verification
The hardest situation to reach is a range that crosses the top of the circular region. The crossing must happen exactly on an odd or an even byte, so that a word is split across the jump back to `ring_lo`. Random runs place a small region at a random base, start inside it and choose lengths up to the region size, so many runs cross it with both parities. Directed runs cover the jump at 1FFFh, a one-byte range, the three-byte reference value, and a second start request injected in the middle of a busy run with different pointers.

// File: rtl/csum_pkg.sv
package csum_pkg;

  localparam int DEF_ADDR_W = 13;
  localparam int DEF_DATA_W = 8;

  typedef enum logic [1:0] {
    ENG_IDLE  = 2'd0,
    ENG_FETCH = 2'd1,
    ENG_DRAIN = 2'd2
  } eng_state_e;

endpackage

// File: rtl/csum_ctrl.sv
module csum_ctrl
  import csum_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic go_set,
  input  logic mode_csum,
  input  logic flag_clr,
  input  logic en_src,
  input  logic en_glb,
  input  logic issue_last,
  input  logic consume_last,
  output logic start_pulse,
  output logic go_q,
  output logic done_q,
  output logic irq_q
);

  eng_state_e st_q;

  // accept only from idle and only in checksum mode
  assign start_pulse = go_set && mode_csum && (st_q == ENG_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= ENG_IDLE;
    end else begin
      case (st_q)
        ENG_IDLE:  if (start_pulse)  st_q <= ENG_FETCH;
        ENG_FETCH: if (issue_last)   st_q <= ENG_DRAIN;
        ENG_DRAIN: if (consume_last) st_q <= ENG_IDLE;
        default:                     st_q <= ENG_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      go_q   <= 1'b0;
      done_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      if (start_pulse)       go_q <= 1'b1;
      else if (consume_last) go_q <= 1'b0;

      // completion wins over a host clear on the same edge
      if (consume_last)  done_q <= 1'b1;
      else if (flag_clr) done_q <= 1'b0;

      irq_q <= done_q && en_src && en_glb;
    end
  end

endmodule

// File: rtl/csum_addr_gen.sv
module csum_addr_gen #(
  parameter int AW = 13
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [AW-1:0] ptr_start,
  input  logic [AW-1:0] ptr_end,
  input  logic [AW-1:0] ring_lo,
  input  logic [AW-1:0] ring_hi,
  output logic          rd_en,
  output logic [AW-1:0] rd_addr,
  output logic          issue_last,
  output logic          vld_q,
  output logic          last_q
);

  logic          fetching_q;
  logic [AW-1:0] addr_q;
  logic [AW-1:0] end_l;
  logic [AW-1:0] lo_l;
  logic [AW-1:0] hi_l;
  logic [AW-1:0] addr_nxt;

  // region bounds are latched so host writes during a run change nothing
  always_comb begin
    if (addr_q == hi_l) addr_nxt = lo_l;
    else                addr_nxt = addr_q + 1'b1;
  end

  assign issue_last = fetching_q && (addr_q == end_l);
  assign rd_en      = fetching_q;
  assign rd_addr    = addr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      fetching_q <= 1'b0;
      addr_q     <= '0;
      end_l      <= '0;
      lo_l       <= '0;
      hi_l       <= '0;
    end else if (load) begin
      fetching_q <= 1'b1;
      addr_q     <= ptr_start;
      end_l      <= ptr_end;
      lo_l       <= ring_lo;
      hi_l       <= ring_hi;
    end else if (fetching_q) begin
      addr_q <= addr_nxt;
      if (issue_last) fetching_q <= 1'b0;
    end
  end

  // data returns one cycle after the read, so the tags follow by one cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q  <= 1'b0;
      last_q <= 1'b0;
    end else begin
      vld_q  <= fetching_q;
      last_q <= issue_last;
    end
  end

endmodule

// File: rtl/csum_accum.sv
module csum_accum #(
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clear,
  input  logic            vld,
  input  logic            last,
  input  logic [DW-1:0]   byte_in,
  output logic [2*DW-1:0] res_q
);

  localparam int SW = 2 * DW;

  logic          hi_ph_q;
  logic [DW-1:0] hold_q;
  logic [SW-1:0] acc_q;
  logic [SW-1:0] word;
  logic [SW:0]   raw;
  logic [SW-1:0] acc_nxt;
  logic          take;

  always_comb begin
    // a lone high byte at the end is padded with a zero low byte
    if (hi_ph_q) word = {byte_in, {DW{1'b0}}};
    else         word = {hold_q, byte_in};
    take    = vld && (!hi_ph_q || last);
    raw     = {1'b0, acc_q} + {1'b0, word};
    acc_nxt = raw[SW-1:0] + {{(SW-1){1'b0}}, raw[SW]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_ph_q <= 1'b1;
      hold_q  <= '0;
      acc_q   <= '0;
      res_q   <= '0;
    end else if (clear) begin
      hi_ph_q <= 1'b1;
      acc_q   <= '0;
    end else if (vld) begin
      hi_ph_q <= ~hi_ph_q;
      if (hi_ph_q) hold_q <= byte_in;
      if (take)    acc_q  <= acc_nxt;
      if (last)    res_q  <= ~acc_nxt;
    end
  end

endmodule

// File: rtl/inet_csum_engine.sv
module inet_csum_engine
  import csum_pkg::*;
#(
  parameter int AW = DEF_ADDR_W,
  parameter int DW = DEF_DATA_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          mode_csum,
  input  logic          go_set,
  input  logic          flag_clr,
  input  logic          irq_en_src,
  input  logic          irq_en_glb,
  input  logic [AW-1:0] ptr_start,
  input  logic [AW-1:0] ptr_end,
  input  logic [AW-1:0] ring_lo,
  input  logic [AW-1:0] ring_hi,
  output logic          mem_rd_en,
  output logic [AW-1:0] mem_addr,
  input  logic [DW-1:0] mem_rd_data,
  output logic          go_bit,
  output logic          done_flag,
  output logic          irq,
  output logic [DW-1:0] sum_hi,
  output logic [DW-1:0] sum_lo
);

  localparam int SW = 2 * DW;

  logic          start_pulse;
  logic          issue_last;
  logic          vld_q;
  logic          last_q;
  logic          consume_last;
  logic [SW-1:0] res;

  assign consume_last = vld_q && last_q;

  csum_ctrl u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .go_set       (go_set),
    .mode_csum    (mode_csum),
    .flag_clr     (flag_clr),
    .en_src       (irq_en_src),
    .en_glb       (irq_en_glb),
    .issue_last   (issue_last),
    .consume_last (consume_last),
    .start_pulse  (start_pulse),
    .go_q         (go_bit),
    .done_q       (done_flag),
    .irq_q        (irq)
  );

  csum_addr_gen #(.AW(AW)) u_agen (
    .clk        (clk),
    .rst        (rst),
    .load       (start_pulse),
    .ptr_start  (ptr_start),
    .ptr_end    (ptr_end),
    .ring_lo    (ring_lo),
    .ring_hi    (ring_hi),
    .rd_en      (mem_rd_en),
    .rd_addr    (mem_addr),
    .issue_last (issue_last),
    .vld_q      (vld_q),
    .last_q     (last_q)
  );

  csum_accum #(.DW(DW)) u_acc (
    .clk     (clk),
    .rst     (rst),
    .clear   (start_pulse),
    .vld     (vld_q),
    .last    (last_q),
    .byte_in (mem_rd_data),
    .res_q   (res)
  );

  assign sum_hi = res[SW-1:DW];
  assign sum_lo = res[DW-1:0];

endmodule

// File: rtl/inet_csum_engine_chk.sv
module inet_csum_engine_chk #(
  parameter int AW = 13,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          mode_csum,
  input logic          irq_en_src,
  input logic          irq_en_glb,
  input logic          mem_rd_en,
  input logic [AW-1:0] mem_addr,
  input logic          go_bit,
  input logic          done_flag,
  input logic          irq,
  input logic [DW-1:0] sum_hi,
  input logic [DW-1:0] sum_lo
);

  AST_READ_ONLY_WHEN_BUSY: assert property (@(posedge clk) disable iff (rst)
    mem_rd_en |-> go_bit); // R3

  AST_READS_END_BEFORE_DONE: assert property (@(posedge clk) disable iff (rst)
    $fell(mem_rd_en) |-> go_bit); // R7

  AST_DONE_AT_FINISH: assert property (@(posedge clk) disable iff (rst)
    $fell(go_bit) |-> done_flag); // R7

  AST_NO_START_WITHOUT_MODE: assert property (@(posedge clk) disable iff (rst)
    (!go_bit && !mode_csum) |=> !go_bit); // R6

  AST_IRQ_NEEDS_ALL: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(done_flag && irq_en_src && irq_en_glb)); // R8

  AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    (done_flag && irq_en_src && irq_en_glb) |=> irq); // R8

  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (rst)
    go_bit |=> ($stable({sum_hi, sum_lo}) || !go_bit)); // R9

endmodule

bind inet_csum_engine inet_csum_engine_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .mode_csum  (mode_csum),
  .irq_en_src (irq_en_src),
  .irq_en_glb (irq_en_glb),
  .mem_rd_en  (mem_rd_en),
  .mem_addr   (mem_addr),
  .go_bit     (go_bit),
  .done_flag  (done_flag),
  .irq        (irq),
  .sum_hi     (sum_hi),
  .sum_lo     (sum_lo)
);

// File: tb/sim_inet_csum_engine.sv
module sim_inet_csum_engine;

  localparam int AW = 13;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          mode_csum = 1'b0, go_set = 1'b0, flag_clr = 1'b0;
  logic          irq_en_src = 1'b0, irq_en_glb = 1'b0;
  logic [AW-1:0] ptr_start = '0, ptr_end = '0, ring_lo = '0, ring_hi = '1;
  logic          mem_rd_en;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_rd_data = '0;
  logic          go_bit, done_flag, irq;
  logic [DW-1:0] sum_hi, sum_lo;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;
  int salt = 0;
  bit patch_on = 0;
  logic [AW-1:0] patch_base = '0;
  logic [7:0] patch [4];

  always #10 clk = ~clk;

  inet_csum_engine #(.AW(AW), .DW(DW)) u0 (
    .clk(clk), .rst(rst), .mode_csum(mode_csum), .go_set(go_set),
    .flag_clr(flag_clr), .irq_en_src(irq_en_src), .irq_en_glb(irq_en_glb),
    .ptr_start(ptr_start), .ptr_end(ptr_end), .ring_lo(ring_lo), .ring_hi(ring_hi),
    .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .mem_rd_data(mem_rd_data),
    .go_bit(go_bit), .done_flag(done_flag), .irq(irq), .sum_hi(sum_hi), .sum_lo(sum_lo)
  );

  function automatic logic [7:0] mem_byte(input logic [AW-1:0] a);
    logic [AW-1:0] off;
    off = a - patch_base;
    if (patch_on && off < 4) return patch[off[1:0]];
    return 8'(a * 29 + salt * 7 + (a >> 3)) ^ 8'(salt >> 2);
  endfunction

  // synchronous buffer model: data one cycle after the read
  always @(posedge clk) if (mem_rd_en) mem_rd_data <= mem_byte(mem_addr);

  function automatic logic [AW-1:0] step(input logic [AW-1:0] a, lo, hi);
    if (a == hi) return lo;
    return a + 1'b1;
  endfunction

  function automatic int range_len(input logic [AW-1:0] s, e, lo, hi);
    logic [AW-1:0] a;
    int n;
    a = s; n = 1;
    while (a != e && n < 9000) begin a = step(a, lo, hi); n++; end
    return n;
  endfunction

  function automatic logic [15:0] ref_sum(input logic [AW-1:0] s, e, lo, hi);
    logic [AW-1:0] a;
    logic [16:0] t;
    logic [15:0] acc, w;
    int n;
    a = s; acc = 16'h0;
    n = range_len(s, e, lo, hi);
    for (int i = 0; i < n; i += 2) begin
      w[15:8] = mem_byte(a);
      if (i + 1 < n) begin a = step(a, lo, hi); w[7:0] = mem_byte(a); end
      else w[7:0] = 8'h00;
      a = step(a, lo, hi);
      t = {1'b0, acc} + {1'b0, w};
      acc = t[15:0] + {15'd0, t[16]};
    end
    return ~acc;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one computation; poke >= 0 injects a second start request at that busy cycle
  task automatic run(input logic [AW-1:0] s, e, lo, hi, input int poke, input string tag);
    logic [15:0] exp_res, prev;
    logic [AW-1:0] exp_addr;
    int n, cyc, nrd;
    n = range_len(s, e, lo, hi);
    exp_res = ref_sum(s, e, lo, hi);
    prev = {sum_hi, sum_lo};
    @(negedge clk);
    ptr_start = s; ptr_end = e; ring_lo = lo; ring_hi = hi;
    mode_csum = 1'b1; go_set = 1'b1;
    @(posedge clk); @(negedge clk);
    go_set = 1'b0;
    cyc = 0; nrd = 0; exp_addr = s;
    while (go_bit && cyc < 20000) begin
      if (mem_rd_en) begin
        if (mem_addr != exp_addr)
          check(0, {"R3/R5 address ", tag}, 32'(mem_addr), 32'(exp_addr));
        exp_addr = step(exp_addr, lo, hi);
        nrd++;
      end
      if (cyc == 1 && n > 2) check({sum_hi, sum_lo} == prev, {"R9 held ", tag}, {sum_hi, sum_lo}, prev);
      if (cyc == poke) begin
        go_set = 1'b1; ptr_start = s + 13'd5; ptr_end = s + 13'd6;
      end else go_set = 1'b0;
      @(posedge clk); @(negedge clk);
      cyc++;
    end
    go_set = 1'b0;
    check(cyc == n + 1, {"R7 busy cycles ", tag}, 32'(cyc), 32'(n + 1));
    check(nrd == n, {"R3 read count ", tag}, 32'(nrd), 32'(n));
    check({sum_hi, sum_lo} == exp_res, {"R1 result ", tag}, {sum_hi, sum_lo}, exp_res);
    check(done_flag == 1'b1, {"R7 done ", tag}, 32'(done_flag), 1);
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0C5A));
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    check(go_bit == 0,   "R11 go",   32'(go_bit), 0);
    check(done_flag == 0,"R11 done", 32'(done_flag), 0);
    check(irq == 0,      "R11 irq",  32'(irq), 0);
    check(mem_rd_en == 0,"R11 rd",   32'(mem_rd_en), 0);
    check({sum_hi, sum_lo} == 0, "R11 result", {sum_hi, sum_lo}, 0);

    // R6 no start without mode
    mode_csum = 1'b0; go_set = 1'b1;
    @(posedge clk); @(negedge clk); go_set = 1'b0;
    for (int i = 0; i < 4; i++) begin
      check(go_bit == 0 && mem_rd_en == 0, "R6 ignored without mode", {go_bit, mem_rd_en}, 0);
      @(posedge clk); @(negedge clk);
    end

    // R2 reference bytes
    patch_on = 1; patch_base = 13'd100;
    patch[0] = 8'h89; patch[1] = 8'hAB; patch[2] = 8'hCD; patch[3] = 8'h00;
    run(13'd100, 13'd102, 13'd0, 13'h1FFF, -1, "R2 89ABCD");
    check({sum_hi, sum_lo} == 16'hA953, "R2 A953", {sum_hi, sum_lo}, 16'hA953);
    check(sum_hi == 8'hA9 && sum_lo == 8'h53, "R9 byte split", {sum_hi, sum_lo}, 16'hA953);

    // R4 single byte
    run(13'd101, 13'd101, 13'd0, 13'h1FFF, -1, "R4 one byte");
    check({sum_hi, sum_lo} == 16'h54FF, "R4 one byte value", {sum_hi, sum_lo}, 16'h54FF);
    patch_on = 0;

    // R8 interrupt gating and clear
    irq_en_src = 1'b1; irq_en_glb = 1'b0;
    @(posedge clk); @(negedge clk);
    check(irq == 0, "R8 global off", 32'(irq), 0);
    irq_en_glb = 1'b1;
    @(posedge clk); @(negedge clk);
    check(irq == 1, "R8 all on", 32'(irq), 1);
    flag_clr = 1'b1;
    @(posedge clk); @(negedge clk); flag_clr = 1'b0;
    check(done_flag == 0, "R8 clear", 32'(done_flag), 0);
    @(posedge clk); @(negedge clk);
    check(irq == 0, "R8 irq drops", 32'(irq), 0);

    // R5 wrap at top of address space and at region end
    salt = 3;
    run(13'h1FFD, 13'd2, 13'd0, 13'h1FFF, -1, "R5 space wrap");
    run(13'd510, 13'd404, 13'd400, 13'd511, -1, "R5 ring wrap odd");
    run(13'd509, 13'd404, 13'd400, 13'd511, -1, "R5 ring wrap even");

    // R10 restart while busy ignored
    run(13'd700, 13'd730, 13'd0, 13'h1FFF, 6, "R10 busy restart");

    // random runs
    for (int k = 0; k < 40; k++) begin
      logic [AW-1:0] lo, hi, s, e;
      int span, len;
      salt = int'($urandom % 251);
      lo = 13'($urandom % 7000);
      span = 8 + int'($urandom % 120);
      hi = lo + 13'(span - 1);
      s = lo + 13'($urandom % span);
      len = 1 + int'($urandom % span);
      e = s;
      for (int j = 1; j < len; j++) e = step(e, lo, hi);
      flag_clr = 1'b1; @(negedge clk); flag_clr = 1'b0;
      run(s, e, lo, hi, (k % 5 == 0) ? 2 : -1, "R1 random");
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule